// File: doc/BRIEF.md
# Refresh Request Bus Master

This block issues DRAM refresh cycles as bus-master byte reads on a 16-bit system bus with asynchronous-style strobes. Refresh requests come either from an internal free-running divider or from an external active-low request pin. The pin is synchronized and only its falling edges count as requests. Each request produces exactly one bus cycle. That cycle reads the current refresh address, and the address then steps forward and wraps at a bound that software sets.

The cycle follows the same arbitration as an on-chip DMA channel. The block raises a bus request and a bus-clear request, waits for the grant, and then drives the address, the address strobe, one data strobe and a refresh function code. It ends the cycle on a data acknowledge or a bus error. A bus error is not retried. It writes a fixed channel code into an error register and sets a sticky flag that software clears. Row and column strobe generation and address multiplexing are left to external glue logic.

Top module: `refresh_bus_master`

## Requirements
- R1: During a refresh cycle exactly one of `uds_n` and `lds_n` is low. Both are high outside the strobe phase.
- R2: When `addr_o[0]` is 1, the cycle drives `lds_n` low. When `addr_o[0]` is 0, it drives `uds_n` low.
- R3: With `use_ext_req`=1, each falling edge of `ext_req_n` passes through a two-flop synchronizer and then yields exactly one refresh cycle.
- R4: A request that arrives while an earlier request is still waiting for the grant merges with it. Both together produce a single cycle.
- R5: With `use_ext_req`=0, the internal divider raises a request every `DIV_TC` clocks (default 260). Successive `bus_req` rises are therefore exactly 260 clocks apart.
- R6: For a pending request, `bus_req` and `bus_clear` rise together. `as_n` and the data strobes go low only in the clock after `bus_grant` is seen, and `bus_clear` is low from then on. `bus_req` drops in the clock after `dtack_n` or `berr_n` is seen low.
- R7: `fc` is 3'b101 while `as_n` is low and 3'b000 otherwise.
- R8: A bus error ends the cycle without a retry. `err_code` becomes 16'h0001 and `err_flag` becomes 1. `err_flag` stays set until an `err_clr` pulse.
- R9: The refresh address starts at 0 and steps by one after every finished cycle, including cycles that end in a bus error. After the cycle at `addr_limit`, it wraps to 0.
- R10: While `enable` is 0, `bus_req` stays low, requests are ignored, and any pending request is discarded.
- R11: After reset, `bus_req`, `bus_clear` and `err_flag` are 0, `as_n`/`uds_n`/`lds_n` are 1, `fc` is 0 and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| use_ext_req | input | 1 | 1: requests from pin, 0: internal divider |
| ext_req_n | input | 1 | Asynchronous request pin, falling edge requests |
| addr_limit | input | ADDR_W | Highest refresh address before wrapping |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| bus_clear | output | 1 | Bus-clear request to other masters |
| addr_o | output | ADDR_W | Refresh address |
| as_n | output | 1 | Address strobe, active low |
| uds_n | output | 1 | Upper data strobe, active low |
| lds_n | output | 1 | Lower data strobe, active low |
| fc | output | 3 | Function code |
| dtack_n | input | 1 | Data acknowledge, active low |
| berr_n | input | 1 | Bus error, active low |
| err_clr | input | 1 | Clears the sticky error flag |
| err_code | output | 16 | Bus-error channel-number register |
| err_flag | output | 1 | Sticky bus-error flag |

## Verification
Three corner cases are targeted by the bench.

The address wrap is run many times with a small bound and checked together with strobe parity. A design that steps wrongly, or skips the step after a bus error, would drive the wrong strobe or address. The bench also checks that a bus-error cycle is not retried, because a retry would repeat the same address.

Two pin edges are sent while the grant is withheld. A design that counted requests instead of merging them would run a second, unrequested cycle. The block is also disabled while a request waits, and a design that kept the pending request would claim the bus once it is re-enabled.

The spacing between divider-driven requests is measured exactly, which exposes an off-by-one terminal count.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_STRB = 2'd2,
    ST_REL  = 2'd3
  } rfr_state_t;

  localparam logic [15:0] RFR_ERR_CODE = 16'h0001;
endpackage

// File: rtl/rfr_req_src.sv
module rfr_req_src #(
  parameter int unsigned DIV_TC = 260
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic use_ext,
  input  logic ext_req_n,
  output logic req_pulse
);
  localparam int unsigned DIV_W = (DIV_TC > 2) ? $clog2(DIV_TC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_TC - 1);

  logic [2:0]       sync_q, sync_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             div_tick, ext_fall;

  always_comb begin
    sync_d   = {sync_q[1:0], ext_req_n};
    ext_fall = sync_q[2] & ~sync_q[1];
    div_tick = (cnt_q == DIV_LAST);
    if (!enable || use_ext)  cnt_d = '0;
    else if (div_tick)       cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
    req_pulse = enable & (use_ext ? ext_fall : div_tick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/rfr_addr_step.sv
module rfr_addr_step #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [ADDR_W-1:0] limit,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (step) begin
      if (addr_q >= limit) addr_d = '0;
      else                 addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (step) addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/rfr_bus_fsm.sv
module rfr_bus_fsm
  import rfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       req_pulse,
  input  logic       bus_grant,
  input  logic       dtack_n,
  input  logic       berr_n,
  output rfr_state_t state,
  output logic       cycle_done,
  output logic       cycle_err
);
  rfr_state_t state_q, state_d;
  logic       pend_q, pend_d, take;

  always_comb begin
    take       = enable && (state_q == ST_REQ) && bus_grant;
    cycle_done = enable && (state_q == ST_STRB) && (!dtack_n || !berr_n);
    cycle_err  = enable && (state_q == ST_STRB) && !berr_n;
    pend_d     = enable && (req_pulse || (pend_q && !take));
    state_d    = state_q;
    if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (pend_q)     state_d = ST_REQ;
        ST_REQ:  if (bus_grant)  state_d = ST_STRB;
        ST_STRB: if (cycle_done) state_d = ST_REL;
        ST_REL:                  state_d = ST_IDLE;
        default:                 state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/refresh_bus_master.sv
module refresh_bus_master
  import rfr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DIV_TC     = 260,
  parameter logic [2:0]  FC_REFRESH = 3'b101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              use_ext_req,
  input  logic              ext_req_n,
  input  logic [ADDR_W-1:0] addr_limit,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              bus_clear,
  output logic [ADDR_W-1:0] addr_o,
  output logic              as_n,
  output logic              uds_n,
  output logic              lds_n,
  output logic [2:0]        fc,
  input  logic              dtack_n,
  input  logic              berr_n,
  input  logic              err_clr,
  output logic [15:0]       err_code,
  output logic              err_flag
);
  logic       req_pulse, cycle_done, cycle_err, strobing;
  rfr_state_t state;
  logic [15:0] code_q, code_d;
  logic        flag_q, flag_d;

  rfr_req_src #(.DIV_TC(DIV_TC)) u_src (
    .clk(clk), .rst_n(rst_n), .enable(enable), .use_ext(use_ext_req),
    .ext_req_n(ext_req_n), .req_pulse(req_pulse)
  );

  rfr_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .req_pulse(req_pulse),
    .bus_grant(bus_grant), .dtack_n(dtack_n), .berr_n(berr_n),
    .state(state), .cycle_done(cycle_done), .cycle_err(cycle_err)
  );

  rfr_addr_step #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .step(cycle_done), .limit(addr_limit),
    .addr(addr_o)
  );

  always_comb begin
    code_d = cycle_err ? RFR_ERR_CODE : code_q;
    if (cycle_err)    flag_d = 1'b1;
    else if (err_clr) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cycle_err) code_q <= code_d;
      flag_q <= flag_d;
    end
  end

  assign strobing  = (state == ST_STRB);
  assign bus_req   = (state == ST_REQ) || strobing;
  assign bus_clear = (state == ST_REQ);
  assign as_n      = !strobing;
  assign uds_n     = !(strobing && !addr_o[0]);
  assign lds_n     = !(strobing && addr_o[0]);
  assign fc        = strobing ? FC_REFRESH : 3'b000;
  assign err_code  = code_q;
  assign err_flag  = flag_q;
endmodule

// File: rtl/rfr_bus_master_chk.sv
module rfr_bus_master_chk #(
  parameter int unsigned ADDR_W     = 24,
  parameter logic [2:0]  FC_REFRESH = 3'b101
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [ADDR_W-1:0] addr_o,
  input logic              bus_req,
  input logic              bus_grant,
  input logic              bus_clear,
  input logic              as_n,
  input logic              uds_n,
  input logic              lds_n,
  input logic [2:0]        fc,
  input logic              berr_n,
  input logic [15:0]       err_code,
  input logic              err_flag
);
  // R1
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> (uds_n != lds_n));
  a_r1_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (uds_n && lds_n));
  // R2
  a_r2_parity: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> (lds_n == !addr_o[0]));
  // R6
  a_r6_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_n) |-> $past(bus_grant));
  a_r6_clear_phase: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clear |-> (bus_req && as_n));
  // R7
  a_r7_fc_code: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> (fc == FC_REFRESH));
  a_r7_fc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (fc == 3'b000));
  // R8
  a_r8_err_log: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !as_n && !berr_n) |=> (err_flag && err_code == 16'h0001 && as_n));
  // R10
  a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !bus_req);
endmodule

bind refresh_bus_master rfr_bus_master_chk #(
  .ADDR_W(ADDR_W), .FC_REFRESH(FC_REFRESH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .addr_o(addr_o),
  .bus_req(bus_req), .bus_grant(bus_grant), .bus_clear(bus_clear),
  .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n), .fc(fc), .berr_n(berr_n),
  .err_code(err_code), .err_flag(err_flag)
);

// File: tb/test_refresh_bus_master.sv
module test_refresh_bus_master;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, use_ext_req = 1'b1, ext_req_n = 1'b1;
  logic [AW-1:0] addr_limit = 24'd5;
  logic bus_grant = 1'b0, dtack_n = 1'b1, berr_n = 1'b1, err_clr = 1'b0;
  logic bus_req, bus_clear, as_n, uds_n, lds_n, err_flag;
  logic [AW-1:0] addr_o;
  logic [2:0] fc;
  logic [15:0] err_code;

  int checks = 0, errors = 0, cyc = 0;
  logic [AW-1:0] exp_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refresh_bus_master i_refresh_bus_master (
    .clk(clk), .rst_n(rst_n), .enable(enable), .use_ext_req(use_ext_req),
    .ext_req_n(ext_req_n), .addr_limit(addr_limit), .bus_req(bus_req),
    .bus_grant(bus_grant), .bus_clear(bus_clear), .addr_o(addr_o),
    .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n), .fc(fc), .dtack_n(dtack_n),
    .berr_n(berr_n), .err_clr(err_clr), .err_code(err_code), .err_flag(err_flag)
  );

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a,
                                               input logic [AW-1:0] lim);
    return (a >= lim) ? '0 : a + 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_req(output int t);
    t = -1;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (bus_req) begin t = cyc; break; end
    end
    chk(t >= 0, "R3/R5 request seen", 0, 1);
  endtask

  task automatic serve(input bit do_berr, input int gdelay, output int t);
    wait_req(t);
    chk(bus_clear && as_n, "R6 clear with request", {bus_clear, as_n}, 2'b11);
    repeat (gdelay) @(negedge clk);
    chk(as_n, "R6 no strobe before grant", as_n, 1);
    bus_grant = 1'b1;
    @(negedge clk);
    chk(!as_n && !bus_clear, "R6 strobe after grant", {as_n, bus_clear}, 2'b00);
    chk(addr_o == exp_addr, "R9 address", addr_o, exp_addr);
    chk({uds_n, lds_n} == {exp_addr[0], ~exp_addr[0]}, "R2 strobe by parity",
        {uds_n, lds_n}, {exp_addr[0], ~exp_addr[0]});
    chk(uds_n != lds_n, "R1 single strobe", {uds_n, lds_n}, 2'b01);
    chk(fc == 3'b101, "R7 fc code", fc, 3'b101);
    if (do_berr) berr_n = 1'b0; else dtack_n = 1'b0;
    @(negedge clk);
    chk(!bus_req && as_n && uds_n && lds_n, "R6 release", {bus_req, as_n}, 2'b01);
    chk(fc == 3'b000, "R7 fc idle", fc, 0);
    if (do_berr)
      chk(err_flag && err_code == 16'h0001, "R8 error logged", err_code, 16'h0001);
    bus_grant = 1'b0; dtack_n = 1'b1; berr_n = 1'b1;
    exp_addr = next_addr(exp_addr, addr_limit);
    @(negedge clk);
  endtask

  task automatic pin_fall();
    ext_req_n = 1'b0; repeat (4) @(negedge clk);
    ext_req_n = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (bus_req) seen = 1; end
    chk(!seen, req, seen, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int t1, t2;
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!bus_req && !bus_clear && as_n && uds_n && lds_n && fc == 0,
        "R11 bus idle at reset", {bus_req, bus_clear, as_n, uds_n, lds_n}, 5'b00111);
    chk(err_code == 0 && !err_flag, "R11 error state at reset", err_code, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 disabled: pin edges ignored
    pin_fall();
    quiet(30, "R10 no request while disabled");

    // R5 divider interval
    enable = 1'b1; use_ext_req = 1'b0;
    serve(1'b0, 0, t1);
    serve(1'b0, 0, t2);
    chk(t2 - t1 == 260, "R5 divider interval", t2 - t1, 260);

    // R3 external edges, R4 merge
    use_ext_req = 1'b1;
    repeat (5) @(negedge clk);
    pin_fall();
    serve(1'b0, 1, t1);
    quiet(30, "R3 one cycle per edge");
    pin_fall();
    pin_fall();
    serve(1'b0, 0, t1);
    quiet(30, "R4 merged request gives one cycle");

    // R8 error: not retried, sticky, cleared by software
    pin_fall();
    serve(1'b1, 2, t1);
    quiet(20, "R8 no retry after error");
    pin_fall();
    serve(1'b0, 0, t1);
    chk(err_flag, "R8 flag sticky", err_flag, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    chk(!err_flag && err_code == 16'h0001, "R8 flag cleared", err_flag, 0);

    // R10 pending request discarded on disable
    pin_fall();
    chk(bus_req, "R10 request before disable", bus_req, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(!bus_req, "R10 request dropped", bus_req, 0);
    enable = 1'b1;
    quiet(30, "R10 pending discarded");

    // Random cycles across the address wrap (R9)
    for (int k = 0; k < 30; k++) begin
      bit be = ($urandom_range(3) == 0);
      pin_fall();
      serve(be, $urandom_range(5), t1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule